// File: doc/BRIEF.md
# Width-Configurable External Address Mapper

The block turns a CPU word address into the values driven on an external memory bus that has two chip-select regions. Each region has its own small bus configuration register. The register holds a physical memory width and a data item size. The pair stored there decides how the word address is shifted onto the external pins, which byte strobes fire, and which data lanes carry the transfer.

With the full-width setting, the external address equals the internal one and all four byte strobes of the region go low. With the half-width setting, the address is shifted right by one bit and the top bit is copied into the two highest pins. Only the two low strobes go low, and the highest strobe of the region is reused as an extra least-significant address pin. An access that falls in neither region drives no strobe. A register setting outside the two supported pairs falls back to the full-width mapping and raises an error flag.

Top module: `ext_addr_mapper`

## Requirements
- R1: After reset, both region registers hold the full-width setting (width code 2'b10, size code 2'b10), and the outputs are idle: `ext_addr_o` is 0, `ben_o` is all ones, `lane_o` is 2'b00 and `err_o` is 0.
- R2: In a cycle with `req_i` low, the next output cycle is idle: all strobes are high, lanes are 2'b00, the address is 0 and there is no error.
- R3: In a region set to full width, `ext_addr_o` equals the request address, all four strobes of that region are low, and `lane_o` is 2'b11 (all 32 lanes).
- R4: In a region set to half width (width code 2'b01, size code 2'b01), `ext_addr_o` is the address shifted right by one with bit 23 copied into bits 23 and 22. Strobe bits 0 and 1 of the region are low, bit 2 is high, and `lane_o` is 2'b01 (low 16 lanes).
- R5: In half width, bit 3 of the region's strobe group carries address bit 0. For example, 900000h gives C80000h with that pin 0, and 900001h gives C80000h with that pin 1.
- R6: Region 0 spans 000000h–3FFFFFh and region 1 spans 800000h–FFFFFFh. Strobes for region r are `ben_o[4r+3:4r]`, and at most one group is ever active. An address outside both regions gives idle outputs.
- R7: Each region's mapping is taken only from its own register, so changing one region leaves the other region's accesses unchanged.
- R8: A write (`cfg_we_i`, `cfg_sel_i` picking the region, `cfg_wdata_i[1:0]` the width code, `cfg_wdata_i[3:2]` the size code) applies to requests from the next cycle on. A request in the write cycle uses the old setting.
- R9: Any code pair other than the two supported ones maps as full width, with `err_o` high for that access.
- R10: All outputs are registered. A request sampled at one rising edge appears on the pins right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 1 | Region picked for the write |
| cfg_wdata_i | input | 4 | {size code, width code} |
| req_i | input | 1 | Access request |
| addr_i | input | 24 | CPU word address |
| ext_addr_o | output | 24 | External address pins |
| ben_o | output | 8 | Active-low byte strobes, 4 per region |
| lane_o | output | 2 | Data lanes used: 00 none, 01 low half, 11 all |
| err_o | output | 1 | Unsupported setting used for this access |

## Verification
The hardest case to reach is a request that lands in the same cycle as a write to its own region's register. Only that case shows whether the old setting is still applied. The stimulus issues the first region-1 write together with a request to 900001h and expects the full-width result. It then repeats the address after the write and expects the half-width result. Region boundaries (3FFFFFh, 400000h, 800000h, FFFFFFh) and both odd and even half-width addresses are driven to exercise the reused strobe pin.

// File: rtl/ext_map_pkg.sv
package ext_map_pkg;

  localparam int BE_W = 4;

  typedef enum logic [1:0] {
    SZ_8   = 2'b00,
    SZ_16  = 2'b01,
    SZ_32  = 2'b10,
    SZ_RSV = 2'b11
  } size_e;

  // packed order gives dsize in [3:2], pwidth in [1:0]
  typedef struct packed {
    size_e dsize;
    size_e pwidth;
  } bus_cfg_t;

  typedef enum logic [1:0] {
    LANE_NONE = 2'b00,
    LANE_LO   = 2'b01,
    LANE_ALL  = 2'b11
  } lane_e;

  typedef enum logic [1:0] {
    MAP_W32,
    MAP_W16,
    MAP_BAD
  } map_e;

  localparam bus_cfg_t CFG_RST = '{dsize: SZ_32, pwidth: SZ_32};

  function automatic map_e classify(input bus_cfg_t c);
    if (c.pwidth == SZ_32 && c.dsize == SZ_32) return MAP_W32;
    if (c.pwidth == SZ_16 && c.dsize == SZ_16) return MAP_W16;
    return MAP_BAD;
  endfunction

endpackage

// File: rtl/ext_map_cfg_regs.sv
module ext_map_cfg_regs
  import ext_map_pkg::*;
#(
  parameter int NREG  = 2,
  localparam int SEL_W = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [SEL_W-1:0]    sel_i,
  input  logic [$bits(bus_cfg_t)-1:0] wdata_i,
  output bus_cfg_t            cfg_o [NREG]
);

  bus_cfg_t cfg_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cfg_q[g] <= CFG_RST;
      end else if (we_i && sel_i == SEL_W'(g)) begin
        cfg_q[g] <= bus_cfg_t'(wdata_i);
      end
    end
    assign cfg_o[g] = cfg_q[g];
  end

endmodule

// File: rtl/ext_map_region_dec.sv
module ext_map_region_dec #(
  parameter int ADDR_W = 24,
  parameter int NREG   = 2,
  parameter logic [NREG*ADDR_W-1:0] LO = '0,
  parameter logic [NREG*ADDR_W-1:0] HI = '1
) (
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [NREG-1:0]   hit_o
);

  logic [NREG-1:0] raw;

  for (genvar g = 0; g < NREG; g++) begin : g_rng
    localparam logic [ADDR_W-1:0] BASE = LO[g*ADDR_W +: ADDR_W];
    localparam logic [ADDR_W-1:0] SPAN = HI[g*ADDR_W +: ADDR_W] - BASE;
    logic [ADDR_W-1:0] off;
    // single unsigned compare covers both bounds
    assign off    = addr_i - BASE;
    assign raw[g] = req_i && (off <= SPAN);
  end

  // lowest index wins on overlap
  always_comb begin
    logic found;
    found = 1'b0;
    hit_o = '0;
    for (int i = 0; i < NREG; i++) begin
      if (raw[i] && !found) begin
        hit_o[i] = 1'b1;
        found    = 1'b1;
      end
    end
  end

endmodule

// File: rtl/ext_map_xlate.sv
module ext_map_xlate
  import ext_map_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  bus_cfg_t          cfg_i,
  output logic [ADDR_W-1:0] ext_addr_o,
  output logic [BE_W-1:0]   ben_o,
  output lane_e             lane_o,
  output logic              err_o
);

  map_e mode;
  assign mode = classify(cfg_i);

  always_comb begin
    ext_addr_o = addr_i;
    ben_o      = '0;
    lane_o     = LANE_ALL;
    err_o      = 1'b0;
    unique case (mode)
      MAP_W16: begin
        ext_addr_o = {addr_i[ADDR_W-1], addr_i[ADDR_W-1:1]};
        // top strobe reused as the sub-word address pin
        ben_o      = {addr_i[0], 1'b1, 2'b00};
        lane_o     = LANE_LO;
      end
      MAP_BAD: err_o = 1'b1;
      default: ;
    endcase
  end

endmodule

// File: rtl/ext_addr_mapper.sv
module ext_addr_mapper
  import ext_map_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int NREG   = 2,
  parameter logic [NREG*ADDR_W-1:0] REG_LO = {24'h800000, 24'h000000},
  parameter logic [NREG*ADDR_W-1:0] REG_HI = {24'hFFFFFF, 24'h3FFFFF},
  localparam int SEL_W = (NREG > 1) ? $clog2(NREG) : 1,
  localparam int CFG_W = $bits(bus_cfg_t)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cfg_we_i,
  input  logic [SEL_W-1:0]     cfg_sel_i,
  input  logic [CFG_W-1:0]     cfg_wdata_i,
  input  logic                 req_i,
  input  logic [ADDR_W-1:0]    addr_i,
  output logic [ADDR_W-1:0]    ext_addr_o,
  output logic [NREG*BE_W-1:0] ben_o,
  output logic [1:0]           lane_o,
  output logic                 err_o
);

  bus_cfg_t          cfg [NREG];
  logic [NREG-1:0]   hit;
  logic [ADDR_W-1:0] x_ext  [NREG];
  logic [BE_W-1:0]   x_ben  [NREG];
  lane_e             x_lane [NREG];
  logic              x_err  [NREG];

  ext_map_cfg_regs #(.NREG(NREG)) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .sel_i   (cfg_sel_i),
    .wdata_i (cfg_wdata_i),
    .cfg_o   (cfg)
  );

  ext_map_region_dec #(
    .ADDR_W (ADDR_W),
    .NREG   (NREG),
    .LO     (REG_LO),
    .HI     (REG_HI)
  ) u_dec (
    .req_i  (req_i),
    .addr_i (addr_i),
    .hit_o  (hit)
  );

  for (genvar r = 0; r < NREG; r++) begin : g_xl
    ext_map_xlate #(.ADDR_W(ADDR_W)) u_xl (
      .addr_i     (addr_i),
      .cfg_i      (cfg[r]),
      .ext_addr_o (x_ext[r]),
      .ben_o      (x_ben[r]),
      .lane_o     (x_lane[r]),
      .err_o      (x_err[r])
    );
  end

  logic [ADDR_W-1:0]    ext_d;
  logic [NREG*BE_W-1:0] ben_d;
  lane_e                lane_d;
  logic                 err_d;

  always_comb begin
    ext_d  = '0;
    ben_d  = '1;
    lane_d = LANE_NONE;
    err_d  = 1'b0;
    for (int r = 0; r < NREG; r++) begin
      if (hit[r]) begin
        ext_d               = x_ext[r];
        ben_d[r*BE_W +: BE_W] = x_ben[r];
        lane_d              = x_lane[r];
        err_d               = x_err[r];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ext_addr_o <= '0;
      ben_o      <= '1;
      lane_o     <= LANE_NONE;
      err_o      <= 1'b0;
    end else begin
      ext_addr_o <= ext_d;
      ben_o      <= ben_d;
      lane_o     <= lane_d;
      err_o      <= err_d;
    end
  end

endmodule

// File: rtl/ext_addr_mapper_chk.sv
module ext_addr_mapper_chk #(
  parameter int ADDR_W = 24,
  parameter int NREG   = 2,
  parameter int BE_W   = 4
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 req_i,
  input logic [ADDR_W-1:0]    addr_i,
  input logic [ADDR_W-1:0]    ext_addr_o,
  input logic [NREG*BE_W-1:0] ben_o,
  input logic [1:0]           lane_o,
  input logic                 err_o
);

  logic            past_ok;
  logic [NREG-1:0] act;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  for (genvar r = 0; r < NREG; r++) begin : g_act
    assign act[r] = ben_o[r*BE_W +: 2] != 2'b11;
  end

  assert_idle_after_no_req_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && !$past(req_i)) |-> (ben_o == '1 && lane_o == 2'b00 && !err_o));

  assert_one_region_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(act));

  assert_lane_matches_strobe_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lane_o != 2'b00) == (act != '0));

  assert_full_addr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && lane_o == 2'b11) |-> ext_addr_o == $past(addr_i));

  assert_half_addr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && lane_o == 2'b01) |->
      ext_addr_o == {$past(addr_i[ADDR_W-1]), $past(addr_i[ADDR_W-1:1])});

  assert_err_full_map_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> lane_o == 2'b11);

  assert_lane_code_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lane_o != 2'b10);

endmodule

bind ext_addr_mapper ext_addr_mapper_chk #(
  .ADDR_W (ADDR_W),
  .NREG   (NREG),
  .BE_W   (ext_map_pkg::BE_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_i      (req_i),
  .addr_i     (addr_i),
  .ext_addr_o (ext_addr_o),
  .ben_o      (ben_o),
  .lane_o     (lane_o),
  .err_o      (err_o)
);

// File: tb/ext_addr_mapper_bench.sv
module ext_addr_mapper_bench;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [0:0]  cfg_sel_i = '0;
  logic [3:0]  cfg_wdata_i = '0;
  logic        req_i = 1'b0;
  logic [23:0] addr_i = '0;
  logic [23:0] ext_addr_o;
  logic [7:0]  ben_o;
  logic [1:0]  lane_o;
  logic        err_o;

  int total = 0;
  int bad   = 0;

  always #4 clk_i = ~clk_i;

  ext_addr_mapper u_ext_addr_mapper (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_we_i    (cfg_we_i),
    .cfg_sel_i   (cfg_sel_i),
    .cfg_wdata_i (cfg_wdata_i),
    .req_i       (req_i),
    .addr_i      (addr_i),
    .ext_addr_o  (ext_addr_o),
    .ben_o       (ben_o),
    .lane_o      (lane_o),
    .err_o       (err_o)
  );

  typedef struct {
    logic [23:0] ext;
    logic [7:0]  ben;
    logic [1:0]  lane;
    logic        err;
    string       tag;
  } exp_t;

  exp_t       sb [$];
  logic [3:0] mcfg [2] = '{4'b1010, 4'b1010};

  function automatic exp_t model(input logic rq, input logic [23:0] a, input string tag);
    exp_t e;
    int   r;
    e.ext = '0; e.ben = 8'hFF; e.lane = 2'b00; e.err = 1'b0; e.tag = tag;
    r = -1;
    if (rq && a <= 24'h3FFFFF) r = 0;
    else if (rq && a >= 24'h800000) r = 1;
    if (r >= 0) begin
      if (mcfg[r] == 4'b0101) begin
        e.ext = {a[23], a[23:1]};
        e.ben[r*4 +: 4] = {a[0], 1'b1, 2'b00};
        e.lane = 2'b01;
      end else begin
        e.ext = a;
        e.ben[r*4 +: 4] = 4'b0000;
        e.lane = 2'b11;
        e.err = (mcfg[r] != 4'b1010);
      end
    end
    return e;
  endfunction

  task automatic step(input logic rq, input logic [23:0] a, input logic we,
                      input logic sel, input logic [3:0] wd, input string tag);
    @(negedge clk_i);
    req_i = rq; addr_i = a; cfg_we_i = we; cfg_sel_i = sel; cfg_wdata_i = wd;
    sb.push_back(model(rq, a, tag));
    if (we) mcfg[sel] = wd;
  endtask

  task automatic acc(input logic [23:0] a, input string tag);
    step(1'b1, a, 1'b0, 1'b0, 4'h0, tag);
  endtask

  // monitor: one expected item per cycle, checked just after the edge
  always @(posedge clk_i) begin
    #1;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      total++;
      if (ext_addr_o !== e.ext || ben_o !== e.ben || lane_o !== e.lane || err_o !== e.err) begin
        bad++;
        $display("FAIL %s got ext=%h ben=%b lane=%b err=%b exp ext=%h ben=%b lane=%b err=%b",
                 e.tag, ext_addr_o, ben_o, lane_o, err_o, e.ext, e.ben, e.lane, e.err);
      end
    end
  end

  initial begin
    #(8 * 20000);
    total++; bad++;
    $display("FAIL R10 watchdog expired got=hang exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    total++;
    if (ext_addr_o !== 24'h0 || ben_o !== 8'hFF || lane_o !== 2'b00 || err_o !== 1'b0) begin
      bad++;
      $display("FAIL R1 reset got ext=%h ben=%b lane=%b err=%b exp ext=000000 ben=11111111 lane=00 err=0",
               ext_addr_o, ben_o, lane_o, err_o);
    end

    step(1'b0, 24'h004000, 1'b0, 1'b0, 4'h0, "R2 idle");
    acc(24'h004000, "R3 R10 full 4000");
    acc(24'h004001, "R3 full 4001");
    acc(24'h004002, "R3 full 4002");
    acc(24'h004003, "R3 full 4003");
    acc(24'h900000, "R1 region1 reset cfg");
    step(1'b0, 24'h900000, 1'b0, 1'b0, 4'h0, "R2 idle after access");
    acc(24'h500000, "R6 miss gap");
    acc(24'h3FFFFF, "R6 top of region0");
    acc(24'h400000, "R6 just above region0");
    // write region1 to half width with a same-cycle request
    step(1'b1, 24'h900001, 1'b1, 1'b1, 4'b0101, "R8 old cfg in write cycle");
    acc(24'h900000, "R4 R5 half even");
    acc(24'h900001, "R5 half odd");
    acc(24'h004002, "R7 region0 unchanged");
    acc(24'hFFFFFF, "R4 top of region1");
    acc(24'h800000, "R4 R6 base of region1");
    step(1'b1, 24'h004001, 1'b1, 1'b0, 4'b0110, "R8 write region0 bad");
    acc(24'h004001, "R9 mixed codes");
    acc(24'h900001, "R7 region1 unchanged");
    step(1'b0, 24'h0, 1'b1, 1'b0, 4'b0000, "R2 idle during write");
    acc(24'h000007, "R9 byte codes");
    step(1'b0, 24'h0, 1'b1, 1'b0, 4'b1010, "R2 restore");
    acc(24'h000007, "R8 restored full");
    step(1'b0, 24'h0, 1'b0, 1'b0, 4'h0, "R2 final idle");
    while (sb.size() > 0) @(posedge clk_i);
    repeat (2) @(posedge clk_i);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule